// File: doc/BRIEF.md
# Two-Bank Overlapped Burst Sequencer

This block fetches one four-longword cache line (16 bytes, four 32-bit words in a single transaction) from a pair of memory banks and hands the words, in order, to a shared 32-bit system data bus. A requester presents a start request with a mode flag, a bank choice and a base word index inside the bank. In linear mode all four words come from the chosen bank. The first word costs the full access latency and each later word costs the shorter page-mode latency. In paired mode the even bank supplies words 1 and 3 and the odd bank supplies words 2 and 4. Both banks start at the same time, so the odd bank's first access runs under the even bank's.

Each bank has its own engine with an activity strobe, a column read strobe, a word address and a one-word capture register. A small ordering stage drains those registers onto the shared bus one beat per cycle, strictly in word order. A word that arrives before its turn waits in its bank's register. While that register is full and not being drained, the bank holds its next access. Latencies are parameters counted in clock cycles. Address decoding, refresh and electrical DRAM timing are left to the surrounding logic.

The request side is a valid/ready handshake. A request is taken on an edge where both `req_valid` and `req_ready` are high, and `req_ready` is high only while no burst is in flight. The beat side is a plain valid strobe with no back-pressure: the sink must take every beat in the cycle it appears.

Top module: `ilv_burst_seq`

## Requirements
- R1: `req_ready` is high exactly when no burst is in flight. A request taken on edge E drops `req_ready` from E onward. A `req_valid` pulse while `req_ready` is low starts nothing: no extra beats appear and no bank becomes active after the current burst ends.
- R2: Linear mode (`req_interleave`=0) reads all four words from the bank named by `req_bank` (0 even, 1 odd), at word addresses base, base+1, base+2, base+3 modulo 2^AW. Beat k (k=0..3) is presented after edge FIRST_LAT+1+k*PAGE_LAT counted from the accept edge. The other bank stays inactive.
- R3: Paired mode (`req_interleave`=1, `req_bank` ignored) presents beats 0 and 2 from the even bank at addresses base and base+1. Beats 1 and 3 come from the odd bank at addresses base and base+1.
- R4: In paired mode the beats are presented after edges F+1, F+2, max(F+P+1, F+3) and max(F+P+2, F+4) from the accept edge (F=FIRST_LAT, P=PAGE_LAT). A bank whose capture register is full and not being drained holds its access until the register frees.
- R5: Each burst gives exactly four `beat_valid` pulses, in word order. `beat_last` is high with the fourth pulse only. A captured word is not altered before it is drained.
- R6: On the first cycle after the accept edge, `row_act` equals 2'b11 in paired mode, or the one-hot of the chosen bank (bit 0 even, bit 1 odd) in linear mode. `row_act` is 2'b00 once the burst has ended.
- R7: With PAGE_LAT of at least 2, a paired burst ends in fewer cycles than a linear burst.
- R8: After reset, `req_ready` is 1 and `beat_valid`, `beat_last` and `row_act` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Request accepted this edge if valid; high only when idle |
| req_interleave | input | 1 | 1 = paired two-bank burst, 0 = linear single-bank burst |
| req_bank | input | 1 | Bank for linear mode (0 even, 1 odd) |
| req_base | input | AW | Base word index inside the bank(s) |
| row_act | output | 2 | Per-bank activity strobe, bit 0 even bank |
| col_strb | output | 2 | Per-bank read strobe: word on that bank's read data is taken when its register has room |
| bank0_addr | output | AW | Even bank word address |
| bank1_addr | output | AW | Odd bank word address |
| bank0_rdata | input | DW | Even bank read data for `bank0_addr` |
| bank1_rdata | input | DW | Odd bank read data for `bank1_addr` |
| beat_valid | output | 1 | One beat on the system bus this cycle |
| beat_data | output | DW | Beat word |
| beat_last | output | 1 | Fourth beat of the burst |

## Verification
The assertions take for granted that each bank's read data is a function of that bank's address alone. They also take for granted that the data is steady while the read strobe is high, and that the beat sink never stalls, since the block has no way to hold a beat. The bench models each bank as a pure function of bank number and address, driven continuously from the address outputs. It drives requests only on falling edges and offers a request during a burst only as a one-cycle pulse. The sweep covers both modes, both bank choices and bases that wrap around the end of the address space.

// File: rtl/ilv_burst_pkg.sv
package ilv_burst_pkg;
  typedef enum logic {
    MODE_LINEAR = 1'b0,
    MODE_PAIRED = 1'b1
  } burst_mode_e;

  localparam int unsigned BEATS_PER_BURST = 4;
  localparam int unsigned BANKS = 2;
endpackage

// File: rtl/ilv_bank_engine.sv
module ilv_bank_engine #(
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 8,
  parameter int unsigned FIRST_LAT = 5,
  parameter int unsigned PAGE_LAT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    start_words,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] rdata,
  input  logic          drain,
  output logic          row_act,
  output logic          col_strb,
  output logic [AW-1:0] col_addr,
  output logic          buf_valid,
  output logic [DW-1:0] buf_data
);
  localparam int unsigned CW = $clog2(FIRST_LAT + 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [2:0]    left;
  logic [AW-1:0] addr;
  logic          take;

  assign row_act  = active;
  assign col_addr = addr;
  assign col_strb = active && (cnt == CW'(1));
  assign take     = col_strb && (!buf_valid || drain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      left   <= '0;
      addr   <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CW'(FIRST_LAT);
      left   <= start_words;
      addr   <= start_addr;
    end else if (active) begin
      if (take) begin
        left <= left - 3'd1;
        addr <= addr + AW'(1);
        cnt  <= CW'(PAGE_LAT);
        if (left == 3'd1) active <= 1'b0;
      end else if (cnt > CW'(1)) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_data  <= '0;
    end else if (take) begin
      buf_valid <= 1'b1;
      buf_data  <= rdata;
    end else if (drain) begin
      buf_valid <= 1'b0;
    end
  end

  // R5: a held word keeps its value until the ordering stage drains it
  p_held_word_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !drain) |=> (buf_valid && $stable(buf_data)));

  // R4: a bank blocked by a full register keeps its strobe and address
  p_stall_holds_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_strb && buf_valid && !drain && !start) |=> (col_strb && $stable(col_addr)));
endmodule

// File: rtl/ilv_beat_order.sv
module ilv_beat_order #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          paired,
  input  logic          sel_bank,
  input  logic [1:0]    buf_valid,
  input  logic [DW-1:0] buf_data0,
  input  logic [DW-1:0] buf_data1,
  output logic [1:0]    drain,
  output logic          done,
  output logic          beat_valid,
  output logic [DW-1:0] beat_data,
  output logic          beat_last
);
  logic       running;
  logic [1:0] nb;
  logic       src;
  logic       can;

  assign src   = paired ? nb[0] : sel_bank;
  assign can   = running && buf_valid[src];
  assign drain = can ? (src ? 2'b10 : 2'b01) : 2'b00;
  assign done  = can && (nb == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      nb         <= '0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      beat_data  <= '0;
    end else begin
      beat_valid <= can;
      beat_last  <= done;
      if (can) beat_data <= src ? buf_data1 : buf_data0;
      if (start) begin
        running <= 1'b1;
        nb      <= '0;
      end else if (can) begin
        nb <= nb + 2'd1;
        if (nb == 2'd3) running <= 1'b0;
      end
    end
  end

  // R5: the closing marker never appears without a beat
  p_last_has_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);
endmodule

// File: rtl/ilv_burst_seq.sv
module ilv_burst_seq
  import ilv_burst_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 8,
  parameter int unsigned FIRST_LAT = 5,
  parameter int unsigned PAGE_LAT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_interleave,
  input  logic          req_bank,
  input  logic [AW-1:0] req_base,
  output logic [1:0]    row_act,
  output logic [1:0]    col_strb,
  output logic [AW-1:0] bank0_addr,
  output logic [AW-1:0] bank1_addr,
  input  logic [DW-1:0] bank0_rdata,
  input  logic [DW-1:0] bank1_rdata,
  output logic          beat_valid,
  output logic [DW-1:0] beat_data,
  output logic          beat_last
);
  localparam logic [2:0] WORDS_LINEAR = 3'(BEATS_PER_BURST);
  localparam logic [2:0] WORDS_PAIRED = 3'(BEATS_PER_BURST / BANKS);

  logic        busy;
  logic        start;
  logic        done;
  burst_mode_e mode_q;
  logic        sel_q;
  logic [1:0]  buf_valid;
  logic [1:0]  drain;
  logic [DW-1:0] rdata_a [BANKS];
  logic [DW-1:0] bufd_a  [BANKS];
  logic [AW-1:0] addr_a  [BANKS];

  assign req_ready = !busy;
  assign start     = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= MODE_LINEAR;
      sel_q  <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      mode_q <= req_interleave ? MODE_PAIRED : MODE_LINEAR;
      sel_q  <= req_bank;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  assign rdata_a[0] = bank0_rdata;
  assign rdata_a[1] = bank1_rdata;
  assign bank0_addr = addr_a[0];
  assign bank1_addr = addr_a[1];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_start;
    assign bank_start = start && (req_interleave || (req_bank == 1'(b)));

    ilv_bank_engine #(
      .DW(DW), .AW(AW), .FIRST_LAT(FIRST_LAT), .PAGE_LAT(PAGE_LAT)
    ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (bank_start),
      .start_words(req_interleave ? WORDS_PAIRED : WORDS_LINEAR),
      .start_addr (req_base),
      .rdata      (rdata_a[b]),
      .drain      (drain[b]),
      .row_act    (row_act[b]),
      .col_strb   (col_strb[b]),
      .col_addr   (addr_a[b]),
      .buf_valid  (buf_valid[b]),
      .buf_data   (bufd_a[b])
    );
  end

  ilv_beat_order #(.DW(DW)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .paired    (mode_q == MODE_PAIRED),
    .sel_bank  (sel_q),
    .buf_valid (buf_valid),
    .buf_data0 (bufd_a[0]),
    .buf_data1 (bufd_a[1]),
    .drain     (drain),
    .done      (done),
    .beat_valid(beat_valid),
    .beat_data (beat_data),
    .beat_last (beat_last)
  );

  // R1: a taken request closes the handshake on the next cycle
  p_accept_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1: no new request can be taken while non-final beats stream out
  p_busy_during_beats_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |-> !req_ready);

  // R2: in linear mode the unused bank stays inactive
  p_linear_other_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == MODE_LINEAR) |-> !row_act[!sel_q]);
endmodule

// File: tb/ilv_burst_seq_test.sv
module ilv_burst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int F  = 5;
  localparam int P  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_interleave = 1'b0;
  logic          req_bank = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [1:0]    row_act;
  logic [1:0]    col_strb;
  logic [AW-1:0] bank0_addr;
  logic [AW-1:0] bank1_addr;
  logic [DW-1:0] bank0_rdata;
  logic [DW-1:0] bank1_rdata;
  logic          beat_valid;
  logic [DW-1:0] beat_data;
  logic          beat_last;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  int last_lin = 0;
  int last_ilv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input int bank, input logic [AW-1:0] a);
    logic [7:0] x;
    x = 8'(a);
    return {(bank != 0) ? 8'hB1 : 8'hA0, x, ~x, 8'(x * 8'd3 + 8'd7)};
  endfunction

  assign bank0_rdata = mem_word(0, bank0_addr);
  assign bank1_rdata = mem_word(1, bank1_addr);

  ilv_burst_seq #(.DW(DW), .AW(AW), .FIRST_LAT(F), .PAGE_LAT(P)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_interleave(req_interleave), .req_bank(req_bank), .req_base(req_base),
    .row_act(row_act), .col_strb(col_strb), .bank0_addr(bank0_addr),
    .bank1_addr(bank1_addr), .bank0_rdata(bank0_rdata), .bank1_rdata(bank1_rdata),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_last(beat_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_edge(input int ilv, input int k);
    if (ilv == 0) return F + 1 + k * P;
    case (k)
      0: return F + 1;
      1: return F + 2;
      2: return max2(F + P + 1, F + 3);
      default: return max2(F + P + 2, F + 4);
    endcase
  endfunction

  task automatic run_burst(input int ilv, input int bs, input int base,
                           input bit poke, output int last_edge);
    int got;
    int bank;
    logic [AW-1:0] a;
    logic [DW-1:0] expw;
    got = 0;
    last_edge = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_interleave = 1'(ilv);
    req_bank = 1'(bs);
    req_base = AW'(base);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= 30; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 1) begin
        if (ilv != 0)
          check(row_act == 2'b11, "R6", "paired row_act", 64'(row_act), 64'd3);
        else
          check(row_act == 2'(1 << bs), "R6", "linear row_act", 64'(row_act), 64'(1 << bs));
      end
      if (poke && n == 2) begin
        check(req_ready == 1'b0, "R1", "ready low while busy", 64'(req_ready), 64'd0);
        req_valid = 1'b1;
        req_interleave = ~req_interleave;
        req_bank = ~req_bank;
        req_base = req_base + AW'(17);
      end
      if (poke && n == 3) req_valid = 1'b0;
      if (got < 4 && n == exp_edge(ilv, got)) begin
        if (ilv != 0) begin
          bank = got % 2;
          a = AW'(base + got / 2);
        end else begin
          bank = bs;
          a = AW'(base + got);
        end
        expw = mem_word(bank, a);
        check(beat_valid == 1'b1, (ilv != 0) ? "R4" : "R2", "beat timing",
              64'(beat_valid), 64'd1);
        check(beat_data == expw, (ilv != 0) ? "R3" : "R2", "beat data",
              64'(beat_data), 64'(expw));
        check(beat_last == (got == 3), "R5", "last marker",
              64'(beat_last), 64'(got == 3));
        if (beat_valid && beat_last) last_edge = n;
        got++;
      end else if (beat_valid) begin
        check(1'b0, "R5", "unexpected beat", 64'(n), 64'(exp_edge(ilv, got)));
      end
    end
    check(row_act == 2'b00, "R6", "banks idle after burst", 64'(row_act), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int le;
    int bases[5] = '{0, 1, 126, 253, 255};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R8", "reset ready", 64'(req_ready), 64'd1);
    check(beat_valid == 1'b0 && beat_last == 1'b0, "R8", "reset beat",
          64'({beat_valid, beat_last}), 64'd0);
    check(row_act == 2'b00, "R8", "reset row_act", 64'(row_act), 64'd0);
    rst_n = 1'b1;
    for (int ilv = 0; ilv < 2; ilv++) begin
      for (int bs = 0; bs < 2; bs++) begin
        for (int i = 0; i < 5; i++) begin
          run_burst(ilv, bs, bases[i], (i == 2), le);
          if (ilv == 0) last_lin = le; else last_ilv = le;
          if (i == 2) begin
            // R1: the pulse offered mid-burst must not start anything
            for (int q = 0; q < 15; q++) begin
              @(negedge clk);
              check(!beat_valid && row_act == 2'b00, "R1", "ignored request quiet",
                    64'({beat_valid, row_act}), 64'd0);
            end
          end
        end
      end
    end
    check(last_ilv > 0 && last_lin > 0 && last_ilv < last_lin, "R7",
          "paired faster than linear", 64'(last_ilv), 64'(last_lin));
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule